// File: doc/BRIEF.md
# Paired-Word Stream Serializer

This block takes two data words that arrive side by side in one cycle, qualified by a single shared valid, and turns them into a stream of single words. Each accepted pair leaves in a fixed order. The lower-lane word (slot A) goes out first and the upper-lane word (slot B) follows. After that, the slot A word of the next accepted pair goes out. The input side can offer two words per cycle, but the output side carries only one. The input therefore has a valid/ready handshake that holds upstream back whenever the internal buffer cannot take another pair.

Accepted pairs are stored as double-width entries in a small FIFO. A holding register keeps the pair currently being unloaded. A two-state controller selects slot A or slot B for the output. It releases the holding register only when the slot B beat is taken. At that point it refills the register from the FIFO head, or takes the incoming pair directly when the FIFO is empty. The output also uses valid/ready. A synchronous active-high reset empties the block.

Top module: `pair_serializer`

## Requirements
- R1: In the first cycle after a synchronous reset, `outValid` is 0 and `inReady` is 1.
- R2: `inReady` is 0 exactly when the FIFO holds `DEPTH` pairs. The holding register is not counted, so the block holds at most `DEPTH`+1 pairs.
- R3: Output order per accepted pair: `inWord0` first, then `inWord1`, then `inWord0` of the next accepted pair.
- R4: When the block is empty and a pair is accepted at a clock edge, `outValid` is 1 in the following cycle and `outData` equals that pair's `inWord0`.
- R5: While `outValid` is 1 and `outReady` is 0, `outValid` and `outData` stay unchanged at the next edge.
- R6: With `inValid` and `outReady` held high, `outValid` stays 1 on every cycle after the first word appears. There are no bubbles.
- R7: `outValid` is 0 when neither the FIFO nor the holding register has data.
- R8: A pair offered while `inReady` is 0 is not taken and never appears on the output.
- R9: The FIFO is read only on a cycle where the slot B word of the held pair is being taken, or where the holding register is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Both input words are present |
| inWord0 | input | WORD_W | Word sent first |
| inWord1 | input | WORD_W | Word sent second |
| inReady | output | 1 | Block can accept a pair |
| outValid | output | 1 | `outData` holds a word |
| outData | output | WORD_W | Serialized word |
| outReady | input | 1 | Downstream takes the word |

## Verification
All outputs come straight from registers. `inReady` and `outValid` reflect the state left by the previous edge. A pair taken at edge k is visible as `outData` from the cycle after edge k at the earliest, which is one cycle of latency. The bench drives its inputs just after a falling edge. On the next falling edge it compares `outValid`, `outData` and `inReady` with a queue-based model that was advanced at the rising edge in between, so every result is sampled exactly one register stage after its cause. Directed phases fix the one-cycle latency, long stalls, filling to capacity and a bubble-free continuous run.

// File: rtl/pair_ser_pkg.sv
package pair_ser_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic push;        // write incoming pair into FIFO
    logic pop;         // read FIFO head
    logic loadFifo;    // holding register takes FIFO head
    logic loadBypass;  // holding register takes incoming pair
    logic sel;         // 0: slot A word on output, 1: slot B word
  } ctrlStrobes_t;

  typedef struct packed {
    logic fifoFull;
    logic fifoEmpty;
  } dpStatus_t;

  typedef enum logic {SLOT_A = 1'b0, SLOT_B = 1'b1} slot_e;

endpackage

// File: rtl/pair_fifo.sv
module pair_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic             full,
  output logic             empty
);
  localparam int ADDR_W = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [ADDR_W:0]  wrPtr;
  logic [ADDR_W:0]  rdPtr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr[ADDR_W-1:0]] <= wrData;
  end

  assign rdData = mem[rdPtr[ADDR_W-1:0]];
  assign empty  = (wrPtr == rdPtr);
  assign full   = (wrPtr[ADDR_W] != rdPtr[ADDR_W]) &&
                  (wrPtr[ADDR_W-1:0] == rdPtr[ADDR_W-1:0]);
endmodule

// File: rtl/pair_datapath.sv
module pair_datapath
  import pair_ser_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobes_t       strobes,
  input  logic [WORD_W-1:0]  inWord0,
  input  logic [WORD_W-1:0]  inWord1,
  output logic [WORD_W-1:0]  outData,
  output dpStatus_t          status
);
  localparam int PAIR_W = 2 * WORD_W;

  logic [PAIR_W-1:0] inPair;
  logic [PAIR_W-1:0] fifoHead;
  logic [PAIR_W-1:0] holdPair;
  logic [WORD_W-1:0] lane [2];

  assign inPair = {inWord1, inWord0};

  pair_fifo #(.WIDTH(PAIR_W), .DEPTH(DEPTH)) u_fifo (
    .clk    (clk),
    .rst    (rst),
    .push   (strobes.push),
    .pop    (strobes.pop),
    .wrData (inPair),
    .rdData (fifoHead),
    .full   (status.fifoFull),
    .empty  (status.fifoEmpty)
  );

  always_ff @(posedge clk) begin
    if (rst)                     holdPair <= '0;
    else if (strobes.loadFifo)   holdPair <= fifoHead;
    else if (strobes.loadBypass) holdPair <= inPair;
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign lane[g] = holdPair[g*WORD_W +: WORD_W];
  end

  assign outData = lane[strobes.sel];
endmodule

// File: rtl/pair_control.sv
module pair_control
  import pair_ser_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  input  logic          outReady,
  input  dpStatus_t     status,
  output logic          inReady,
  output logic          outValid,
  output ctrlStrobes_t  strobes
);
  slot_e slot;
  logic  holdValid;
  logic  accept;
  logic  beatDone;
  logic  holdFree;

  assign inReady  = !status.fifoFull;
  assign outValid = holdValid;
  assign accept   = inValid && inReady;
  assign beatDone = holdValid && outReady;
  assign holdFree = !holdValid || (beatDone && slot == SLOT_B);

  always_comb begin
    strobes            = '0;
    strobes.loadFifo   = holdFree && !status.fifoEmpty;
    strobes.loadBypass = holdFree && status.fifoEmpty && accept;
    strobes.pop        = strobes.loadFifo;
    strobes.push       = accept && !strobes.loadBypass;
    strobes.sel        = (slot == SLOT_B);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot      <= SLOT_A;
      holdValid <= 1'b0;
    end else begin
      if (holdFree) holdValid <= strobes.loadFifo || strobes.loadBypass;
      if (beatDone) slot <= (slot == SLOT_A) ? SLOT_B : SLOT_A;
    end
  end
endmodule

// File: rtl/pair_serializer.sv
module pair_serializer
  import pair_ser_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inWord0,
  input  logic [WORD_W-1:0] inWord1,
  output logic              inReady,
  output logic              outValid,
  output logic [WORD_W-1:0] outData,
  input  logic              outReady
);
  ctrlStrobes_t strobes;
  dpStatus_t    status;

  pair_control u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .outReady (outReady),
    .status   (status),
    .inReady  (inReady),
    .outValid (outValid),
    .strobes  (strobes)
  );

  pair_datapath #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .inWord0 (inWord0),
    .inWord1 (inWord1),
    .outData (outData),
    .status  (status)
  );
endmodule

// File: rtl/pair_serializer_chk.sv
module pair_serializer_chk
  import pair_ser_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic [WORD_W-1:0] outData,
  input logic              outReady,
  input ctrlStrobes_t      strobes,
  input dpStatus_t         status
);
  // R1: clean state right after reset
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!outValid && inReady));

  // R2: full FIFO blocks input, and no write lands on a full FIFO
  p_ready_full_r2: assert property (@(posedge clk) disable iff (rst)
    status.fifoFull |-> !inReady);
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    strobes.push |-> !status.fifoFull);

  // R4: accepted pair into an empty block shows up next cycle
  p_latency_r4: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady && !outValid) |=> outValid);

  // R5: output holds during backpressure
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R6: no bubble while stored pairs remain
  p_no_bubble_r6: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady && !status.fifoEmpty) |=> outValid);

  // R8: writes only on handshake
  p_push_handshake_r8: assert property (@(posedge clk) disable iff (rst)
    strobes.push |-> (inValid && inReady));

  // R9: FIFO read only when the slot B beat completes or holding is empty
  p_pop_slot_b_r9: assert property (@(posedge clk) disable iff (rst)
    strobes.pop |-> (!outValid || (strobes.sel && outReady)));
  p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (rst)
    strobes.loadFifo |-> !status.fifoEmpty);
  p_bypass_empty_r7: assert property (@(posedge clk) disable iff (rst)
    strobes.loadBypass |-> (status.fifoEmpty && !strobes.push));
endmodule

bind pair_serializer pair_serializer_chk #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outData  (outData),
  .outReady (outReady),
  .strobes  (strobes),
  .status   (status)
);

// File: tb/tb_pair_serializer.sv
`timescale 1ns/1ps
module tb_pair_serializer;
  localparam int W     = 16;
  localparam int DEPTH = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [W-1:0] inWord0 = '0;
  logic [W-1:0] inWord1 = '0;
  logic         inReady;
  logic         outValid;
  logic [W-1:0] outData;
  logic         outReady = 1'b0;

  always #2.5 clk = ~clk;

  pair_serializer #(.WORD_W(W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inWord0(inWord0),
    .inWord1(inWord1), .inReady(inReady), .outValid(outValid),
    .outData(outData), .outReady(outReady)
  );

  // reference model: queue of stored pairs plus one held pair
  logic [2*W-1:0] q[$];
  logic [2*W-1:0] mHold;
  bit             mValid;
  bit             mSlotB;
  int             seq;
  int             checks;
  int             errors;
  bit             done;

  function automatic logic [W-1:0] mWord();
    return mSlotB ? mHold[2*W-1:W] : mHold[W-1:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // called at a falling edge: compare, drive, advance model at rising edge
  task automatic step(input bit v, input bit rdy);
    bit acc, beat, free;
    chk(outValid == mValid, "R7 R4 outValid", W'(outValid), W'(mValid));
    chk(inReady == (q.size() < DEPTH), "R2 inReady", W'(inReady),
        W'(q.size() < DEPTH));
    if (mValid) chk(outData == mWord(), "R3 R5 outData", outData, mWord());
    inValid  = v;
    inWord0  = W'(2 * seq);
    inWord1  = W'(2 * seq + 1);
    outReady = rdy;
    acc  = v && (q.size() < DEPTH);
    beat = mValid && rdy;
    free = !mValid || (beat && mSlotB);
    @(posedge clk);
    if (beat) mSlotB = !mSlotB;
    if (acc) begin
      q.push_back({inWord1, inWord0});  // R8: only handshaked pairs enter
      seq++;
    end
    if (free) begin
      mValid = (q.size() != 0);
      mSlotB = 1'b0;
      if (mValid) mHold = q.pop_front();
    end
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int bubbles;
    mValid = 0; mSlotB = 0; mHold = '0; seq = 0;
    checks = 0; errors = 0; done = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    // R1
    chk(!outValid, "R1 outValid after reset", W'(outValid), '0);
    chk(inReady, "R1 inReady after reset", W'(inReady), W'(1));

    // R4: single pair into an empty block
    step(1, 0);
    chk(outValid && outData == W'(0), "R4 first word latency", outData, W'(0));
    step(0, 0);
    step(0, 0);                    // R5 stall
    step(0, 1); step(0, 1);        // drain
    step(0, 1);
    chk(!outValid, "R7 empty after drain", W'(outValid), '0);

    // R2 / R8: fill while output is stalled, keep offering when full
    for (int i = 0; i < 12; i++) step(1, 0);
    chk(!inReady, "R2 inReady low when full", W'(inReady), '0);
    for (int i = 0; i < 30; i++) step(0, 1);

    // R6: continuous stream, no bubbles after first word
    bubbles = 0;
    step(1, 1);
    for (int i = 0; i < 40; i++) begin
      if (!outValid) bubbles++;
      step(1, 1);
    end
    chk(bubbles == 0, "R6 bubble count", W'(bubbles), '0);
    for (int i = 0; i < 20; i++) step(0, 1);

    // mixed traffic: R3, R5, R8, R9 via the model
    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) != 0, ($urandom % 3) != 0);
    for (int i = 0; i < 2000; i++)
      step(($urandom % 5) == 0, ($urandom % 4) == 0);
    for (int i = 0; i < 40; i++) step(0, 1);
    chk(!outValid, "R7 empty at end", W'(outValid), '0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule